// File: doc/BRIEF.md
# Flash Status Register Controller

This block keeps the status byte of a NOR-style flash command interface and presents it to the host bus. Single-cycle event pulses arrive from the embedded program/erase sequencer: the sequencer went busy, it finished, a program attempt ran out of retries, an erase attempt ran out of retries, the supply sample after a confirm found no programming voltage, and an erase was suspended. The host writes command bytes through chip enable, write strobe and an 8-bit data bus, and reads the status byte through chip enable and output enable.

The error flags are sticky. Only the clear command or a reset removes them. While the supply flag is set, the block raises a gate output that the command logic uses to refuse new program or erase operations. A status read captures one snapshot when the read starts. That value stays on the data outputs until the host ends the read (chip enable or output enable goes high) and starts a new one. All inputs are sampled on `clk`. `rst` is a synchronous active-high reset. `pd_n` is the active-low reset/power-down pin and is also sampled synchronously.

Top module: `flash_status_ctrl`

## Requirements
- R1: After `rst` or while `pd_n` is low, the status byte is 80h (ready, no flags), status-read mode is off, `dq_oe` is 0 and `pe_block` is 0.
- R2: Status bit 7 (ready) is cleared by a busy pulse and set by a done pulse. If both arrive in the same cycle, set wins.
- R3: Bit 4 (program error) is set by a program-fail pulse and bit 5 (erase error) by an erase-fail pulse. Both stay set through later busy and done pulses.
- R4: Command 50h clears bits 5, 4 and 3 and leaves bits 7 and 6 unchanged. A set pulse in the same cycle wins over the clear.
- R5: A supply-low pulse sets bit 3. From the next cycle, `pe_block` is 1 for as long as bit 3 is set.
- R6: A suspend pulse sets bit 6 and bit 7. Command D0h (resume) clears both bits when bit 6 is set, and changes nothing when bit 6 is clear.
- R7: A command byte is taken on a rising edge of `we_n` seen while `ce_n` is low. A rising edge of `we_n` while `ce_n` is high is ignored.
- R8: Commands 70h, B0h and D0h turn status-read mode on. Command 50h leaves the mode unchanged. Any other byte turns it off.
- R9: In status-read mode, one cycle after `ce_n` and `oe_n` are first seen low together, `dq_oe` is 1 and `dq_out` holds the status byte as it stood before that edge. `dq_out` then stays unchanged until the read ends and a new one starts.
- R10: Bits 2 to 0 of the status byte always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_n | input | 1 | Active-low reset/power-down, sampled on clk |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low; command taken on its rising edge |
| din | input | 8 | Command byte from host |
| ev_busy | input | 1 | Sequencer started an operation |
| ev_done | input | 1 | Sequencer finished an operation |
| ev_pgm_fail | input | 1 | Program retries exhausted without verify |
| ev_ers_fail | input | 1 | Erase retries exhausted without verify |
| ev_supply_low | input | 1 | Supply sample after confirm found no voltage |
| ev_suspend | input | 1 | Erase suspended |
| dq_out | output | 8 | Status byte snapshot for the data bus |
| dq_oe | output | 1 | Data bus drive enable |
| pe_block | output | 1 | Refuse new program/erase operations |

## Verification
Directed sequences first cover each corner in isolation: a write strobe with chip enable high, clear colliding with a fail pulse, resume with and without a pending suspend, and a read held open while flags change. Each of these separates one priority or gating rule from the others. A long seeded random run then mixes sparse event pulses, random command bytes drawn mostly from the defined codes, and randomly toggled read strobes, and compares every cycle against a bench model of the requirements. The random run exposes interactions the directed cases miss, such as a snapshot taken in the same cycle as a flag change, or a mode change in the middle of a read.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int DW = 8;

  localparam logic [DW-1:0] CMD_STATUS  = 8'h70;
  localparam logic [DW-1:0] CMD_CLEAR   = 8'h50;
  localparam logic [DW-1:0] CMD_SUSPEND = 8'hB0;
  localparam logic [DW-1:0] CMD_RESUME  = 8'hD0;

  localparam logic [DW-1:0] STATUS_RESET = 8'h80;

  typedef struct packed {
    logic       ready;
    logic       susp;
    logic       ers_err;
    logic       pgm_err;
    logic       vpp_low;
    logic [2:0] rsvd;
  } status_t;

  typedef struct packed {
    logic clear;
    logic resume;
  } cmd_t;
endpackage

// File: rtl/fsr_cmd_decode.sv
module fsr_cmd_decode
  import fsr_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         ce_n,
  input  logic         we_n,
  input  logic [W-1:0] din,
  output cmd_t         cmd,
  output logic         stat_mode
);
  logic we_q;
  logic take;

  always_ff @(posedge clk) begin
    if (clr) we_q <= 1'b1;
    else     we_q <= we_n;
  end

  assign take = we_n && !we_q && !ce_n;

  always_comb begin
    cmd.clear  = take && (din == CMD_CLEAR);
    cmd.resume = take && (din == CMD_RESUME);
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      stat_mode <= 1'b0;
    end else if (take) begin
      if (din == CMD_STATUS || din == CMD_SUSPEND || din == CMD_RESUME)
        stat_mode <= 1'b1;
      else if (din != CMD_CLEAR)
        stat_mode <= 1'b0;
    end
  end

  a_r7_no_cmd_without_ce: assert property (@(posedge clk) disable iff (clr)
    ce_n |-> !(cmd.clear || cmd.resume));
  a_r8_status_cmd_sets_mode: assert property (@(posedge clk) disable iff (clr)
    (take && din == CMD_STATUS) |=> stat_mode);
endmodule

// File: rtl/fsr_status_reg.sv
module fsr_status_reg
  import fsr_pkg::*;
(
  input  logic    clk,
  input  logic    clr,
  input  cmd_t    cmd,
  input  logic    ev_busy,
  input  logic    ev_done,
  input  logic    ev_pgm_fail,
  input  logic    ev_ers_fail,
  input  logic    ev_supply_low,
  input  logic    ev_suspend,
  output status_t st
);
  status_t nxt;
  logic    do_resume;

  assign do_resume = cmd.resume && st.susp;

  always_comb begin
    nxt = st;
    // ready: clears first, sets win
    if (ev_busy || do_resume)   nxt.ready = 1'b0;
    if (ev_done || ev_suspend)  nxt.ready = 1'b1;
    if (do_resume)              nxt.susp  = 1'b0;
    if (ev_suspend)             nxt.susp  = 1'b1;
    // sticky flags: clear command, then set pulses win
    if (cmd.clear) begin
      nxt.ers_err = 1'b0;
      nxt.pgm_err = 1'b0;
      nxt.vpp_low = 1'b0;
    end
    if (ev_ers_fail)   nxt.ers_err = 1'b1;
    if (ev_pgm_fail)   nxt.pgm_err = 1'b1;
    if (ev_supply_low) nxt.vpp_low = 1'b1;
    nxt.rsvd = '0;
  end

  always_ff @(posedge clk) begin
    if (clr) st <= status_t'(STATUS_RESET);
    else     st <= nxt;
  end

  a_r2_done_sets_ready: assert property (@(posedge clk) disable iff (clr)
    ev_done |=> st.ready);
  a_r3_pgm_sticky: assert property (@(posedge clk) disable iff (clr)
    (st.pgm_err && !cmd.clear) |=> st.pgm_err);
  a_r3_ers_sticky: assert property (@(posedge clk) disable iff (clr)
    (st.ers_err && !cmd.clear) |=> st.ers_err);
  a_r4_clear_keeps_ready: assert property (@(posedge clk) disable iff (clr)
    (cmd.clear && !ev_busy && !ev_done && !ev_suspend) |=> $stable(st.ready));
  a_r6_suspend_sets: assert property (@(posedge clk) disable iff (clr)
    ev_suspend |=> (st.susp && st.ready));
endmodule

// File: rtl/fsr_readout.sv
module fsr_readout
  import fsr_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         stat_mode,
  input  logic         ce_n,
  input  logic         oe_n,
  input  logic [W-1:0] st_val,
  output logic [W-1:0] dq_out,
  output logic         dq_oe
);
  logic rd_en;

  assign rd_en = stat_mode && !ce_n && !oe_n;

  always_ff @(posedge clk) begin
    if (clr) begin
      dq_oe  <= 1'b0;
      dq_out <= '0;
    end else begin
      dq_oe <= rd_en;
      if (rd_en && !dq_oe) dq_out <= st_val;
    end
  end

  a_r9_frozen_read: assert property (@(posedge clk) disable iff (clr)
    (dq_oe && rd_en) |=> $stable(dq_out));
  a_r9_oe_follows: assert property (@(posedge clk) disable iff (clr)
    (ce_n || oe_n) |=> !dq_oe);
endmodule

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
  import fsr_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          pd_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [DW-1:0] din,
  input  logic          ev_busy,
  input  logic          ev_done,
  input  logic          ev_pgm_fail,
  input  logic          ev_ers_fail,
  input  logic          ev_supply_low,
  input  logic          ev_suspend,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic          pe_block
);
  logic    clr;
  cmd_t    cmd;
  logic    stat_mode;
  status_t st;

  assign clr = rst || !pd_n;

  fsr_cmd_decode #(.W(DW)) u_dec (
    .clk(clk), .clr(clr), .ce_n(ce_n), .we_n(we_n), .din(din),
    .cmd(cmd), .stat_mode(stat_mode)
  );

  fsr_status_reg u_st (
    .clk(clk), .clr(clr), .cmd(cmd),
    .ev_busy(ev_busy), .ev_done(ev_done),
    .ev_pgm_fail(ev_pgm_fail), .ev_ers_fail(ev_ers_fail),
    .ev_supply_low(ev_supply_low), .ev_suspend(ev_suspend),
    .st(st)
  );

  fsr_readout #(.W(DW)) u_rd (
    .clk(clk), .clr(clr), .stat_mode(stat_mode), .ce_n(ce_n), .oe_n(oe_n),
    .st_val(st), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  assign pe_block = st.vpp_low;

  a_r5_supply_blocks: assert property (@(posedge clk) disable iff (clr)
    ev_supply_low |=> pe_block);
  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (clr)
    dq_oe |-> (dq_out[2:0] == 3'b000));
  a_r1_pd_clears: assert property (@(posedge clk)
    (!pd_n || rst) |=> (!dq_oe && !pe_block));
endmodule

// File: tb/flash_status_ctrl_test.sv
module flash_status_ctrl_test;
  logic       clk = 1'b0;
  logic       rst, pd_n, ce_n, oe_n, we_n;
  logic [7:0] din;
  logic       ev_busy, ev_done, ev_pgm_fail, ev_ers_fail, ev_supply_low, ev_suspend;
  logic [7:0] dq_out;
  logic       dq_oe, pe_block;

  int n_vec = 0;
  int n_bad = 0;

  // bench model
  logic [7:0] m_st;
  logic       m_mode, m_weq, m_oe;
  logic [7:0] m_dq;

  always #2 clk = ~clk;

  flash_status_ctrl uut (
    .clk(clk), .rst(rst), .pd_n(pd_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .din(din), .ev_busy(ev_busy), .ev_done(ev_done), .ev_pgm_fail(ev_pgm_fail),
    .ev_ers_fail(ev_ers_fail), .ev_supply_low(ev_supply_low), .ev_suspend(ev_suspend),
    .dq_out(dq_out), .dq_oe(dq_oe), .pe_block(pe_block)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] next_status(input logic [7:0] s, input logic clr_c,
                                             input logic res_c);
    logic [7:0] n;
    logic       rs;
    n  = s;
    rs = res_c && s[6];
    if (ev_busy || rs)           n[7] = 1'b0;
    if (ev_done || ev_suspend)   n[7] = 1'b1;
    if (rs)                      n[6] = 1'b0;
    if (ev_suspend)              n[6] = 1'b1;
    if (clr_c)                   n[5:3] = 3'b000;
    if (ev_ers_fail)             n[5] = 1'b1;
    if (ev_pgm_fail)             n[4] = 1'b1;
    if (ev_supply_low)           n[3] = 1'b1;
    n[2:0] = 3'b000;
    return n;
  endfunction

  // one clock: update model with the inputs present at the edge
  task automatic step();
    logic take, rd;
    @(posedge clk);
    if (rst || !pd_n) begin
      m_st = 8'h80; m_mode = 1'b0; m_weq = 1'b1; m_oe = 1'b0; m_dq = 8'h00;
    end else begin
      take = we_n && !m_weq && !ce_n;
      rd   = m_mode && !ce_n && !oe_n;
      if (rd && !m_oe) m_dq = m_st;
      m_oe = rd;
      m_st = next_status(m_st, take && din == 8'h50, take && din == 8'hD0);
      if (take) begin
        if (din == 8'h70 || din == 8'hB0 || din == 8'hD0) m_mode = 1'b1;
        else if (din != 8'h50)                             m_mode = 1'b0;
      end
      m_weq = we_n;
    end
    @(negedge clk);
    ev_busy = 0; ev_done = 0; ev_pgm_fail = 0; ev_ers_fail = 0;
    ev_supply_low = 0; ev_suspend = 0;
  endtask

  task automatic cmd(input logic [7:0] b);
    ce_n = 0; we_n = 0; din = b; step();
    we_n = 1; step();
    ce_n = 1; step();
  endtask

  // open a read, return value seen on the bus
  task automatic read_status(output logic [7:0] v, output logic oe);
    ce_n = 0; oe_n = 0; step();
    v = dq_out; oe = dq_oe;
    ce_n = 1; oe_n = 1; step();
  endtask

  logic [7:0] v;
  logic       o;

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst = 1; pd_n = 1; ce_n = 1; oe_n = 1; we_n = 1; din = 0;
    ev_busy = 0; ev_done = 0; ev_pgm_fail = 0; ev_ers_fail = 0;
    ev_supply_low = 0; ev_suspend = 0;
    @(negedge clk); step(); step();
    rst = 0;

    // R1 reset state
    chk("R1 dq_oe after reset", {7'd0, dq_oe}, 8'h00);
    chk("R1 pe_block after reset", {7'd0, pe_block}, 8'h00);
    cmd(8'h70);
    read_status(v, o);
    chk("R1 status after reset", v, 8'h80);
    chk("R9 dq_oe during read", {7'd0, o}, 8'h01);

    // R2 busy / done
    ev_busy = 1; step(); read_status(v, o);
    chk("R2 busy clears ready", v, 8'h00);
    ev_busy = 1; ev_done = 1; step(); read_status(v, o);
    chk("R2 done wins over busy", v, 8'h80);

    // R3 sticky errors
    ev_pgm_fail = 1; ev_ers_fail = 1; step();
    ev_busy = 1; step(); ev_done = 1; step();
    read_status(v, o);
    chk("R3 errors sticky", v, 8'hB0);

    // R5 supply flag blocks
    ev_supply_low = 1; step();
    chk("R5 pe_block set", {7'd0, pe_block}, 8'h01);
    read_status(v, o);
    chk("R5 bit3 set, R10 low bits zero", v, 8'hB8);

    // R7 write with ce_n high ignored
    ce_n = 1; we_n = 0; din = 8'h50; step(); we_n = 1; step();
    chk("R7 ce_n high command ignored", {7'd0, pe_block}, 8'h01);

    // R4 clear, and set wins in the same cycle
    ce_n = 0; we_n = 0; din = 8'h50; step();
    we_n = 1; ev_pgm_fail = 1; step(); ce_n = 1; step();
    read_status(v, o);
    chk("R4 clear with colliding pgm fail", v, 8'h90);
    chk("R4 pe_block cleared", {7'd0, pe_block}, 8'h00);
    cmd(8'h50); read_status(v, o);
    chk("R8 50h keeps mode, R4 clear", v, 8'h80);

    // R6 suspend / resume
    ev_busy = 1; step();
    cmd(8'hD0); read_status(v, o);
    chk("R6 resume without suspend no effect", v, 8'h00);
    ev_suspend = 1; step(); read_status(v, o);
    chk("R6 suspend sets bits 6 and 7", v, 8'hC0);
    cmd(8'hD0); read_status(v, o);
    chk("R6 resume clears", v, 8'h00);

    // R8 other byte leaves status mode
    cmd(8'hFF); read_status(v, o);
    chk("R8 FFh leaves status mode", {7'd0, o}, 8'h00);
    cmd(8'hB0); read_status(v, o);
    chk("R8 B0h enters status mode", {7'd0, o}, 8'h01);

    // R9 frozen during read
    ce_n = 0; oe_n = 0; step();
    ev_done = 1; ev_ers_fail = 1; step(); step();
    chk("R9 output frozen", dq_out, 8'h00);
    oe_n = 1; step(); oe_n = 0; step();
    chk("R9 new snapshot after toggle", dq_out, 8'hA0);
    ce_n = 1; oe_n = 1; step();

    // R1 power-down clears
    ev_supply_low = 1; step();
    pd_n = 0; step(); pd_n = 1;
    chk("R1 pd clears pe_block", {7'd0, pe_block}, 8'h00);
    cmd(8'h70); read_status(v, o);
    chk("R1 pd status 80h", v, 8'h80);

    // random phase, fixed seed
    void'($urandom(32'd1234));
    for (int i = 0; i < 6000; i++) begin
      logic [3:0] r;
      r = 4'($urandom_range(0, 15));
      ev_busy       = ($urandom_range(0, 19) == 0);
      ev_done       = ($urandom_range(0, 19) == 0);
      ev_pgm_fail   = ($urandom_range(0, 39) == 0);
      ev_ers_fail   = ($urandom_range(0, 39) == 0);
      ev_supply_low = ($urandom_range(0, 39) == 0);
      ev_suspend    = ($urandom_range(0, 39) == 0);
      pd_n          = ($urandom_range(0, 299) != 0);
      ce_n          = ($urandom_range(0, 3) == 0);
      oe_n          = ($urandom_range(0, 2) == 0);
      we_n          = ($urandom_range(0, 2) != 0);
      case (r[1:0])
        2'd0: din = 8'h70;
        2'd1: din = 8'h50;
        2'd2: din = (r[2] ? 8'hD0 : 8'hB0);
        default: din = 8'($urandom);
      endcase
      step();
      chk("R9 random dq_oe", {7'd0, dq_oe}, {7'd0, m_oe});
      if (m_oe) chk("R9 random dq_out", dq_out, m_dq);
      chk("R5 random pe_block", {7'd0, pe_block}, {7'd0, m_st[3]});
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule